// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. It runs the sixteen-state TAP state machine from the test clock and mode select, holds a four-bit instruction, and decodes it to pick one data register for the serial path from test data in to test data out. Three data registers can be picked: a 32-bit identification register, a one-bit bypass register, and a boundary scan chain whose length is a parameter.

The block also produces the controls that the chip's boundary cells need. These are capture, shift and update strobes for the chain, a select that makes the pins take their values from the chain's update stage, and a global output disable. Six instructions are decoded. Two of them, the clamp and float instructions, keep the short bypass path in the scan chain while they hold the pins or float them.

All TAP logic runs on the test clock. The state machine and the shift stages move on the rising edge. Test data out, its enable, the active instruction and the boundary update stage change on the falling edge. An active-low test reset forces the state machine back to Test-Logic-Reset asynchronously.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low, and right after it goes low, the state is Test-Logic-Reset. The active instruction is IDCODE, tdo_oe is 0, bsr_mode is 0, out_disable is 0 and bsr_upd_out is all zeros.
- R2: Five rising test-clock edges with tms high bring the state machine to Test-Logic-Reset from any state. The active instruction then returns to IDCODE.
- R3: In Capture-IR the instruction shift stage loads 4'b0001. Shift-IR moves it out least significant bit first, so tdo shows 1,0,0,0. The instruction codes are EXTEST=0000, SAMPLE=0001, HIGHZ=0101, IDCODE=0110, CLAMP=0111 and BYPASS=1111.
- R4: BYPASS puts the one-bit bypass register in the path. It loads 0 in Capture-DR, so the first bit out is 0 and each later bit is tdi from one shift earlier.
- R5: Any code outside the six listed acts as BYPASS and asserts neither bsr_mode nor out_disable.
- R6: IDCODE shifts out the 32-bit ID_VALUE, least significant bit first. Bit 0 of that value is 1.
- R7: SAMPLE puts the boundary chain in the path. It captures bsr_pins_in in Capture-DR, and Update-DR copies the shifted chain to bsr_upd_out. bsr_mode stays 0.
- R8: EXTEST puts the boundary chain in the path and sets bsr_mode to 1. It captures bsr_pins_in, and bsr_upd_out takes the shifted data at Update-DR.
- R9: CLAMP sets bsr_mode to 1 and puts the bypass register in the path. bsr_upd_out keeps its earlier contents through data scans.
- R10: HIGHZ sets out_disable to 1 and puts the bypass register in the path. bsr_mode is 0 while out_disable is 1.
- R11: A newly shifted instruction does not take effect before Update-IR. bsr_mode and out_disable keep their old values through Shift-IR and Exit1-IR.
- R12: tdo and tdo_oe change on the falling test-clock edge. tdo_oe is 1 only in Shift-IR and Shift-DR.
- R13: bsr_capture, bsr_shift and bsr_update are high only in Capture-DR, Shift-DR and Update-DR, and only when the boundary chain is the selected register. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| bsr_pins_in | input | BSR_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial test data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_capture | output | 1 | Boundary cell capture strobe |
| bsr_shift | output | 1 | Boundary cell shift strobe |
| bsr_update | output | 1 | Boundary cell update strobe |
| bsr_mode | output | 1 | Pins take their values from the boundary update stage |
| out_disable | output | 1 | Global output disable used by the float instruction |
| bsr_upd_out | output | BSR_LEN | Boundary update stage contents |

## Verification
A wrong controller state shows up at tdo_oe and in the bits shifted out. An off-by-one state walk moves the captured pattern or the ID by one bit inside the same scan, and a broken return to reset shows as a bypass zero where the ID's leading 1 should appear. An instruction that is decoded wrongly or loaded too early shows in bsr_mode and out_disable while the pins are still being driven. It shows within one test clock of Update-IR, or in Exit1-IR when an early load is the fault. Capture and update faults in the boundary chain show in bsr_upd_out right after the next Update-DR.

// File: rtl/jtag_pkg.sv
package jtag_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0101;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0110;
    localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0111;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_BSR = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     drive_pins;
        logic     float_pins;
    } op_decode_t;

    function automatic op_decode_t decode_op(input logic [IR_W-1:0] op);
        op_decode_t d;
        d = '{path: PATH_BYP, drive_pins: 1'b0, float_pins: 1'b0};
        case (op)
            OP_EXTEST: d = '{path: PATH_BSR, drive_pins: 1'b1, float_pins: 1'b0};
            OP_SAMPLE: d = '{path: PATH_BSR, drive_pins: 1'b0, float_pins: 1'b0};
            OP_IDCODE: d = '{path: PATH_ID,  drive_pins: 1'b0, float_pins: 1'b0};
            OP_CLAMP:  d = '{path: PATH_BYP, drive_pins: 1'b1, float_pins: 1'b0};
            OP_HIGHZ:  d = '{path: PATH_BYP, drive_pins: 1'b0, float_pins: 1'b1};
            default:   d = '{path: PATH_BYP, drive_pins: 1'b0, float_pins: 1'b0};
        endcase
        return d;
    endfunction

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
    import jtag_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_so,
    output logic [IR_W-1:0] active_op
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= IR_CAPTURE_PAT;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE_PAT;
        end else if (state == ST_SH_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                 active_op <= OP_IDCODE;
        else if (state == ST_RESET)  active_op <= OP_IDCODE;
        else if (state == ST_UPD_IR) active_op <= ir_sr;
    end

    assign ir_so = ir_sr[0];

endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
    import jtag_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h4F1D_C0DB
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_path_e           path,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               dr_so,
    output logic               bsr_capture,
    output logic               bsr_shift,
    output logic               bsr_update,
    output logic [BSR_LEN-1:0] bsr_upd
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic               cap_st, sh_st;

    assign cap_st      = (state == ST_CAP_DR);
    assign sh_st       = (state == ST_SH_DR);
    assign bsr_capture = cap_st && (path == PATH_BSR);
    assign bsr_shift   = sh_st  && (path == PATH_BSR);
    assign bsr_update  = (state == ST_UPD_DR) && (path == PATH_BSR);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q  <= 1'b0;
            id_sr  <= '0;
            bsr_sr <= '0;
        end else begin
            case (path)
                PATH_ID: begin
                    if (cap_st)     id_sr <= ID_VALUE;
                    else if (sh_st) id_sr <= {tdi, id_sr[ID_W-1:1]};
                end
                PATH_BSR: begin
                    if (bsr_capture)    bsr_sr <= pins_in;
                    else if (bsr_shift) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
                end
                default: begin
                    if (cap_st)     byp_q <= 1'b0;
                    else if (sh_st) byp_q <= tdi;
                end
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)         bsr_upd <= '0;
        else if (bsr_update) bsr_upd <= bsr_sr;
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_so = id_sr[0];
            PATH_BSR: dr_so = bsr_sr[0];
            default:  dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h4F1D_C0DB
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bsr_pins_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               bsr_capture,
    output logic               bsr_shift,
    output logic               bsr_update,
    output logic               bsr_mode,
    output logic               out_disable,
    output logic [BSR_LEN-1:0] bsr_upd_out
);

    tap_state_e      state;
    logic [IR_W-1:0] active_ir;
    logic            ir_so, dr_so;
    op_decode_t      dec;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jtag_ir_unit u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .ir_so     (ir_so),
        .active_op (active_ir)
    );

    assign dec         = decode_op(active_ir);
    assign bsr_mode    = dec.drive_pins;
    assign out_disable = dec.float_pins;

    jtag_dr_unit #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .tdi         (tdi),
        .state       (state),
        .path        (dec.path),
        .pins_in     (bsr_pins_in),
        .dr_so       (dr_so),
        .bsr_capture (bsr_capture),
        .bsr_shift   (bsr_shift),
        .bsr_update  (bsr_update),
        .bsr_upd     (bsr_upd_out)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] active_ir,
    input logic            tdo_oe,
    input logic            bsr_capture,
    input logic            bsr_shift,
    input logic            bsr_update,
    input logic            bsr_mode,
    input logic            out_disable
);

    logic [2:0] tms_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        tms_run <= '0;
        else if (!tms)      tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_RESET));

    assert_oe_window_R12: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    assert_late_load_R11: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(active_ir) |-> (state == ST_UPD_IR || state == ST_RESET));

    assert_strobe_excl_R13: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

    assert_shift_oe_R13: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_shift |-> tdo_oe);

    assert_float_nodrive_R10: assert property (@(posedge tck) disable iff (!trst_n)
        out_disable |-> !bsr_mode);

endmodule

bind jtag_tap_ctrl jtag_tap_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .state       (state),
    .active_ir   (active_ir),
    .tdo_oe      (tdo_oe),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update),
    .bsr_mode    (bsr_mode),
    .out_disable (out_disable)
);

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;

    localparam int          N   = 8;
    localparam logic [31:0] IDV = 32'h4F1D_C0DB;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pins = '0;
    logic         tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_mode, out_disable;
    logic [N-1:0] upd;

    always #2 tck = ~tck;

    jtag_tap_ctrl #(.BSR_LEN(N), .ID_VALUE(IDV)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_pins_in(pins),
        .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_mode(bsr_mode), .out_disable(out_disable),
        .bsr_upd_out(upd)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    logic  s_tdo, s_oe, s_sh, s_od, s_md;
    logic  exp_q[$];
    string tag_q[$];
    logic  mon_act;
    logic  mon_exp;
    string mon_tag;
    event  ev_smp;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for serial output bits
    initial begin
        forever begin
            @(ev_smp);
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            n_chk++;
            if (mon_act !== mon_exp) begin
                n_err++;
                $display("FAIL %s tdo bit act=%0b exp=%0b", mon_tag, mon_act, mon_exp);
            end
        end
    end

    task automatic cyc(input logic m, input logic d);
        @(negedge tck);
        #1;
        s_tdo = tdo; s_oe = tdo_oe; s_sh = bsr_shift; s_od = out_disable; s_md = bsr_mode;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic push_bit(input logic e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_act = s_tdo;
        -> ev_smp;
    endtask

    // from Run-Test/Idle; returns bsr_mode/out_disable seen in Exit1-IR
    task automatic scan_ir(input logic [3:0] op, output logic od_x1, output logic md_x1);
        cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(i == 3, op[i]);
            push_bit((i == 0), "R3");
            check("R12 oe in Shift-IR", s_oe, 1);
        end
        cyc(1, 0);
        od_x1 = s_od; md_x1 = s_md;
        cyc(0, 0);
        #1;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] dexp,
                           input logic exp_sh, input string tag);
        cyc(1, 0); cyc(0, 0); cyc(0, 0);
        for (int i = 0; i < n; i++) begin
            cyc(i == n - 1, din[i]);
            push_bit(dexp[i], tag);
            if (i == 0) begin
                check("R12 oe in Shift-DR", s_oe, 1);
                check("R13 bsr_shift", s_sh, exp_sh);
            end
        end
        cyc(1, 0); cyc(0, 0);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic od, md;
        repeat (3) @(posedge tck);
        #1;
        check("R1 oe", tdo_oe, 0);
        check("R1 mode", bsr_mode, 0);
        check("R1 float", out_disable, 0);
        check("R1 upd", upd, 0);
        @(negedge tck); #1; trst_n = 1'b1;
        cyc(0, 0);
        #1;
        check("R12 oe idle", tdo_oe, 0);

        // R6 / R1: IDCODE selected after reset
        scan_dr(32, 64'd0, {32'd0, IDV}, 0, "R6");
        check("R6 id bit0", IDV[0], 1);

        // R7 SAMPLE
        scan_ir(4'b0001, od, md);
        check("R7 mode", bsr_mode, 0);
        pins = 8'hA5;
        scan_dr(N, 64'h3C, 64'hA5, 1, "R7");
        check("R7 update", upd, 8'h3C);

        // R8 EXTEST
        scan_ir(4'b0000, od, md);
        check("R8 mode", bsr_mode, 1);
        pins = 8'h5A;
        scan_dr(N, 64'hC3, 64'h5A, 1, "R8");
        check("R8 update", upd, 8'hC3);

        // R9 CLAMP: bypass path, update stage retained
        scan_ir(4'b0111, od, md);
        check("R9 mode", bsr_mode, 1);
        scan_dr(3, 64'b011, 64'b110, 0, "R9");
        check("R9 upd held", upd, 8'hC3);

        // R11 / R10 HIGHZ
        scan_ir(4'b0101, od, md);
        check("R11 float before update", od, 0);
        check("R11 mode before update", md, 1);
        check("R10 float", out_disable, 1);
        check("R10 mode", bsr_mode, 0);
        scan_dr(2, 64'b01, 64'b10, 0, "R10");

        // R4 BYPASS
        scan_ir(4'b1111, od, md);
        check("R4 float", out_disable, 0);
        scan_dr(5, 64'b01101, 64'b11010, 0, "R4");

        // R5 undefined code
        scan_ir(4'b1010, od, md);
        check("R5 mode", bsr_mode, 0);
        check("R5 float", out_disable, 0);
        scan_dr(4, 64'b1011, 64'b0110, 0, "R5");

        // R2 five TMS-high clocks from Shift-DR
        scan_ir(4'b1111, od, md);
        cyc(1, 0); cyc(0, 0); cyc(0, 0);
        repeat (5) cyc(1, 0);
        cyc(0, 0);
        scan_dr(32, 64'd0, {32'd0, IDV}, 0, "R2");

        // R1 asynchronous reset during EXTEST
        scan_ir(4'b0000, od, md);
        check("R1 pre mode", bsr_mode, 1);
        @(negedge tck); #1; trst_n = 1'b0;
        #0.5;
        check("R1 async mode", bsr_mode, 0);
        check("R1 async upd", upd, 0);
        @(negedge tck); #1; trst_n = 1'b1;
        cyc(0, 0);
        scan_dr(32, 64'd0, {32'd0, IDV}, 0, "R1");

        repeat (2) @(posedge tck);
        finish_run();
    end

endmodule